// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an external static RAM of 4096 words by 4 bits that has no clock of its own. The host issues one request per handshake, either a read or a write. The block turns each request into the RAM's asynchronous pin sequence: address, active-low chip-enable, active-low write-enable, and a 4-bit data output with its own output-enable for the pad tristate buffer. Read data returns to the host with a one-cycle valid strobe.

Every timing minimum of the RAM is a parameter counted in clock cycles. These are the write-enable pulse width, the data setup before the write ends, the full cycle time and the address access time. A write is controlled by write-enable. Chip-enable and write-enable fall together and rise together, so the RAM never turns its outputs on while the block still drives the bus. The block keeps driving the data for one further cycle, which gives a positive hold. Chip-enable returns high between transactions so the RAM can power down.

Top module: `async_sram_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, mem_ce_n and mem_we_n are 1, mem_doe is 0, rd_valid is 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. With req_valid held high, successive acceptances of writes are max(TWC, max(TPWE,TSD)+3) cycles apart, and successive acceptances of reads are max(TWC, TAA+1) cycles apart.
- R3: For a write (req_write=1), mem_addr, mem_dout and mem_doe=1 appear on the acceptance edge while mem_ce_n and mem_we_n stay 1. On the next edge both strobes go to 0 and stay 0 for exactly max(TPWE,TSD) cycles.
- R4: A write ends with mem_we_n and mem_ce_n rising on the same edge. mem_doe stays 1 with mem_dout unchanged for one more cycle and then drops to 0.
- R5: mem_doe is never 1 while mem_ce_n is 0 and mem_we_n is 1, so the block never drives the bus while the RAM's outputs may be on.
- R6: For a read (req_write=0), mem_addr and mem_ce_n=0 appear on the acceptance edge, with mem_we_n=1 and mem_doe=0. mem_din is sampled TAA edges later, and on that same edge mem_ce_n returns to 1.
- R7: rd_valid is a one-cycle pulse that follows the sampling edge. rd_data holds the sampled word until the next read samples, and writes leave it unchanged.
- R8: Whenever req_ready is 1, mem_ce_n is 1. Chip-enable is therefore high for at least one cycle between transactions.
- R9: mem_addr does not change while mem_ce_n stays 0.
- R10: A word written to an address is returned by a later read of that address, across the full 12-bit address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle strobe: rd_data is new |
| rd_data | output | 4 | Last word read |
| mem_addr | output | 12 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip-enable, active low |
| mem_we_n | output | 1 | RAM write-enable, active low |
| mem_dout | output | 4 | Data toward the RAM pad buffer |
| mem_doe | output | 1 | Pad buffer output-enable, active high |
| mem_din | input | 4 | Data coming back from the RAM pads |

## Verification
The properties assume that reset is held for at least one edge before any traffic. They also assume that the host changes its request fields only at the negedge, away from the sampling edge. The bench's RAM model drives mem_din only while chip-enable is low and write-enable is high, and it stores the output word while both strobes are low. The property checks therefore look only at the block's own outputs, and the model never violates the setup or hold timing those outputs rely on. Stimulus is applied at the falling clock edge, and every write precedes the read of the same address.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RWAIT
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic doe;
    } strobe_t;

    localparam strobe_t STROBE_REST = '{ce_n: 1'b1, we_n: 1'b1, doe: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned count_width(input int unsigned top_value);
        return (top_value < 2) ? 1 : $clog2(top_value + 1);
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);
endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 4,
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned PULSE  = 2,
    parameter int unsigned TAA    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_write,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              phase_done,
    output logic              phase_load,
    output logic [CNT_W-1:0]  phase_val,
    output logic              idle,
    output logic              capture,
    output strobe_t           strobe,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] dout_out
);
    localparam logic [CNT_W-1:0] RD_WAIT_LOAD = CNT_W'(TAA - 1);
    localparam logic [CNT_W-1:0] WE_LOW_LOAD  = CNT_W'(PULSE - 1);

    seq_state_t state_q, state_d;
    strobe_t    strobe_q, strobe_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] dout_q, dout_d;

    always_comb begin
        state_d    = state_q;
        strobe_d   = strobe_q;
        addr_d     = addr_q;
        dout_d     = dout_q;
        phase_load = 1'b0;
        phase_val  = '0;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    addr_d = start_addr;
                    if (start_write) begin
                        dout_d       = start_wdata;
                        strobe_d.doe = 1'b1;
                        state_d      = ST_WSETUP;
                    end else begin
                        strobe_d.ce_n = 1'b0;
                        phase_load    = 1'b1;
                        phase_val     = RD_WAIT_LOAD;
                        state_d       = ST_RWAIT;
                    end
                end
            end
            ST_WSETUP: begin
                strobe_d.ce_n = 1'b0;
                strobe_d.we_n = 1'b0;
                phase_load    = 1'b1;
                phase_val     = WE_LOW_LOAD;
                state_d       = ST_WPULSE;
            end
            ST_WPULSE: begin
                if (phase_done) begin
                    strobe_d.ce_n = 1'b1;
                    strobe_d.we_n = 1'b1;
                    state_d       = ST_WHOLD;
                end
            end
            ST_WHOLD: begin
                strobe_d.doe = 1'b0;
                state_d      = ST_IDLE;
            end
            ST_RWAIT: begin
                if (phase_done) begin
                    capture       = 1'b1;
                    strobe_d.ce_n = 1'b1;
                    state_d       = ST_IDLE;
                end
            end
            default: begin
                strobe_d = STROBE_REST;
                state_d  = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            strobe_q <= STROBE_REST;
            addr_q   <= '0;
            dout_q   <= '0;
        end else begin
            state_q  <= state_d;
            strobe_q <= strobe_d;
            addr_q   <= addr_d;
            dout_q   <= dout_d;
        end
    end

    assign idle     = (state_q == ST_IDLE);
    assign strobe   = strobe_q;
    assign addr_out = addr_q;
    assign dout_out = dout_q;
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= capture;
            if (capture) begin
                data <= din;
            end
        end
    end
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 4,
    parameter int unsigned TPWE   = 2,
    parameter int unsigned TSD    = 2,
    parameter int unsigned TWC    = 4,
    parameter int unsigned TAA    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int unsigned PULSE_CYC = max2(TPWE, TSD);
    localparam int unsigned LONGEST   = max2(max2(PULSE_CYC, TWC), TAA);
    localparam int unsigned CNT_W     = count_width(LONGEST);
    localparam logic [CNT_W-1:0] CYCLE_LOAD = CNT_W'(TWC - 1);

    logic             accept;
    logic             seq_idle;
    logic             cycle_done;
    logic             phase_done;
    logic             phase_load;
    logic [CNT_W-1:0] phase_val;
    logic             capture;
    strobe_t          strobe;

    assign req_ready = seq_idle && cycle_done;
    assign accept    = req_valid && req_ready;

    sram_phase_timer #(.CW(CNT_W)) cycle_tmr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (CYCLE_LOAD),
        .expired  (cycle_done)
    );

    sram_phase_timer #(.CW(CNT_W)) phase_tmr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (phase_load),
        .load_val (phase_val),
        .expired  (phase_done)
    );

    sram_strobe_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .PULSE  (PULSE_CYC),
        .TAA    (TAA)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_write (req_write),
        .start_addr  (req_addr),
        .start_wdata (req_wdata),
        .phase_done  (phase_done),
        .phase_load  (phase_load),
        .phase_val   (phase_val),
        .idle        (seq_idle),
        .capture     (capture),
        .strobe      (strobe),
        .addr_out    (mem_addr),
        .dout_out    (mem_dout)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) cap_i (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .din     (mem_din),
        .valid   (rd_valid),
        .data    (rd_data)
    );

    assign mem_ce_n = strobe.ce_n;
    assign mem_we_n = strobe.we_n;
    assign mem_doe  = strobe.doe;
endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 4,
    parameter int unsigned MIN_PULSE = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_doe
);
    logic [15:0] we_low_cycles;

    always_ff @(posedge clk) begin
        if (rst || mem_we_n) begin
            we_low_cycles <= '0;
        end else if (we_low_cycles != 16'hFFFF) begin
            we_low_cycles <= we_low_cycles + 1'b1;
        end
    end

    a_r3_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n);

    a_r3_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_cycles == 16'(MIN_PULSE)));

    a_r4_joint_release: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> $rose(mem_ce_n));

    a_r4_drive_after_end: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_doe);

    a_r4_dout_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_doe && $past(mem_doe)) |-> $stable(mem_dout));

    a_r5_no_fight: assert property (@(posedge clk) disable iff (rst)
        mem_doe |-> (mem_ce_n || !mem_we_n));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r6_read_after_ce: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_ce_n));

    a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n);

    a_r9_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind async_sram_ctrl sram_ctl_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MIN_PULSE (PULSE_CYC)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_dout  (mem_dout),
    .mem_doe   (mem_doe)
);

// File: tb/async_sram_ctrl_tb.sv
module async_sram_ctrl_tb_top;
    localparam int AW    = 12;
    localparam int DW    = 4;
    localparam int TPWE  = 2;
    localparam int TSD   = 2;
    localparam int TWC   = 4;
    localparam int TAA   = 2;
    localparam int PW    = (TPWE > TSD) ? TPWE : TSD;
    localparam int WGAP  = (TWC > PW + 3) ? TWC : PW + 3;
    localparam int RGAP  = (TWC > TAA + 1) ? TWC : TAA + 1;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, mem_ce_n, mem_we_n, mem_doe;
    logic [DW-1:0] rd_data, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;

    logic [DW-1:0] ram [WORDS];
    int checks = 0;
    int fails = 0;
    int fight_cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    async_sram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .TPWE(TPWE), .TSD(TSD), .TWC(TWC), .TAA(TAA)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout),
        .mem_doe(mem_doe), .mem_din(mem_din)
    );

    // RAM model: outputs on while selected for reading; stores while both strobes are low.
    assign mem_din = (!mem_ce_n && mem_we_n) ? ram[mem_addr] : '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_ce_n && !mem_we_n) ram[mem_addr] = mem_dout;
            if (mem_doe && !mem_ce_n && mem_we_n) fight_cycles++;
        end
    end

    function automatic logic [DW-1:0] pattern(input int a);
        return DW'((a * 7 + (a >> 5)) ^ 9);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input int a, input logic [DW-1:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        logic [DW-1:0] rd_before;
        rd_before = rd_data;
        issue(1'b1, a, d);
        chk(mem_doe && mem_ce_n && mem_we_n && mem_addr == AW'(a) && mem_dout == d,
            "R3 setup", {mem_doe, mem_ce_n, mem_we_n}, 3'b111);
        @(negedge clk);
        chk(!mem_ce_n && !mem_we_n, "R3 strobes low", {mem_ce_n, mem_we_n}, 0);
        for (int k = 1; k < PW; k++) begin
            @(negedge clk);
            chk(!mem_we_n && !mem_ce_n, "R3 pulse held", {mem_ce_n, mem_we_n}, 0);
        end
        @(negedge clk);
        chk(mem_we_n && mem_ce_n && mem_doe && mem_dout == d,
            "R4 release with hold", {mem_ce_n, mem_we_n, mem_doe}, 3'b111);
        @(negedge clk);
        chk(!mem_doe, "R4 bus released", mem_doe, 0);
        chk(rd_data == rd_before, "R7 rd_data kept over write", rd_data, rd_before);
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] expv);
        issue(1'b0, a, '0);
        chk(!mem_ce_n && mem_we_n && !mem_doe && mem_addr == AW'(a),
            "R6 read start", {mem_ce_n, mem_we_n, mem_doe}, 3'b010);
        for (int k = 1; k < TAA; k++) begin
            @(negedge clk);
            chk(!mem_ce_n && !rd_valid, "R6 access wait", {mem_ce_n, rd_valid}, 0);
        end
        @(negedge clk);
        chk(rd_valid && mem_ce_n, "R6 sample edge", {rd_valid, mem_ce_n}, 3);
        chk(rd_data == expv, "R10 read data", rd_data, expv);
        @(negedge clk);
        chk(!rd_valid && rd_data == expv, "R7 pulse and hold", {rd_valid, rd_data}, {1'b0, expv});
    endtask

    task automatic gap_test(input bit wr, input int want);
        int last;
        int seen;
        int cyc;
        last = -1; seen = 0; cyc = 0;
        req_write = wr; req_addr = AW'(5); req_wdata = pattern(5);
        req_valid = 1'b1;
        while (seen < 4) begin
            if (req_ready) begin
                chk(mem_ce_n, "R8 ce high at accept", mem_ce_n, 1);
                if (last >= 0) chk(cyc - last == want, "R2 accept spacing", cyc - last, want);
                last = cyc;
                seen++;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && !mem_doe && !rd_valid && req_ready,
            "R1 reset state", {mem_ce_n, mem_we_n, mem_doe, rd_valid, req_ready}, 5'b11001);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && !mem_doe && req_ready, "R1 after reset",
            {mem_ce_n, mem_we_n, mem_doe, req_ready}, 4'b1101);
        for (int a = 0; a < WORDS; a++) do_write(a, pattern(a));
        for (int a = 0; a < WORDS; a++) do_read(a, pattern(a));
        do_write(7, 4'hF);
        do_read(7, 4'hF);
        do_write(WORDS - 1, 4'h0);
        do_read(WORDS - 1, 4'h0);
        gap_test(1'b1, WGAP);
        gap_test(1'b0, RGAP);
        chk(fight_cycles == 0, "R5 bus contention cycles", fight_cycles, 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule